// File: doc/BRIEF.md
# Pipelined Complex Mixer

This block multiplies a stream of complex baseband samples by a complex local-oscillator phasor. The result is a full-precision complex product, so the signal is shifted to the phasor's frequency. The data input is an 18-bit signed I/Q pair with a qualifying valid flag. The phasor input is a 16-bit signed cosine/sine pair from an oscillator that runs at the clock rate. A new sample can be accepted on every clock, and one result leaves per clock.

The arithmetic uses four real multipliers and two adders. The pipeline is arranged to suit FPGA multiply-add slices:
- two register stages on the operands,
- one register stage on the products,
- one register stage on the sums.

The data registers have no reset. Only a valid shift register of matching depth is cleared by reset. Products and sums keep every bit, so there is no rounding, no saturation and no wrap at any stage.

Top module: `cplx_mixer`

## Requirements
- R1: The real output equals a·c − b·s, where a is the real data input, b is the imaginary data input, c is the cosine input and s is the sine input. All values are two's-complement signed, and the output is the exact 35-bit signed result.
- R2: The imaginary output equals a·s + b·c, as an exact 35-bit signed result.
- R3: The data latency is exactly 4 clocks. Operands present at rising edge k produce the result that is visible after rising edge k+4.
- R4: out_valid is in_valid delayed by exactly 4 clocks.
- R5: While rst_n is low, out_valid is 0 whatever in_valid does. Samples offered during reset never produce a valid output.
- R6: The most-negative operands (data −131072, phasor −32768), in every sign combination, give exact results without saturation or wrap. An example is an imaginary result of +2^33.
- R7: Valid samples may arrive on consecutive clocks without gaps. Each one yields its own result 4 clocks later, at the full clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, applied to the valid pipeline only |
| in_valid | input | 1 | Qualifies the data sample on this cycle |
| in_re | input | 18 | Real part of the data sample, signed |
| in_im | input | 18 | Imaginary part of the data sample, signed |
| lo_cos | input | 16 | Phasor cosine, signed |
| lo_sin | input | 16 | Phasor sine, signed |
| out_valid | output | 1 | Qualifies the output sample |
| out_re | output | 35 | Real part of the product, signed, full precision |
| out_im | output | 35 | Imaginary part of the product, signed, full precision |

## Verification
On every cycle after the pipeline has filled, the assertions check three things:
- the four-clock valid delay;
- the step from the product stage to the output stage;
- the exact value of both output components against the operands seen four edges earlier.

Some behaviour only the bench scenarios can show. One is that reset suppresses valid flags offered while rst_n is low. Another is that the most-negative operand combinations come out exact. A third is that a long unbroken run of valid samples each appears in order.

// File: rtl/mixer_pkg.sv
package mixer_pkg;

  localparam int MIX_DATA_W_DEF  = 18;
  localparam int MIX_PHASE_W_DEF = 16;
  localparam int MIX_IN_STAGES   = 2;
  localparam int MIX_LATENCY     = MIX_IN_STAGES + 2;

  function automatic int mix_prod_w(input int dw, input int pw);
    return dw + pw;
  endfunction

  function automatic int mix_sum_w(input int dw, input int pw);
    return dw + pw + 1;
  endfunction

endpackage

// File: rtl/mixer_in_pipe.sv
module mixer_in_pipe #(
  parameter int DW     = 18,
  parameter int PW     = 16,
  parameter int STAGES = 2
) (
  input  logic                 clk,
  input  logic signed [DW-1:0] d_re,
  input  logic signed [DW-1:0] d_im,
  input  logic signed [PW-1:0] p_cos,
  input  logic signed [PW-1:0] p_sin,
  output logic signed [DW-1:0] q_re,
  output logic signed [DW-1:0] q_im,
  output logic signed [PW-1:0] q_cos,
  output logic signed [PW-1:0] q_sin
);

  logic signed [DW-1:0] re_q  [STAGES+1];
  logic signed [DW-1:0] im_q  [STAGES+1];
  logic signed [PW-1:0] cos_q [STAGES+1];
  logic signed [PW-1:0] sin_q [STAGES+1];

  assign re_q[0]  = d_re;
  assign im_q[0]  = d_im;
  assign cos_q[0] = p_cos;
  assign sin_q[0] = p_sin;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    // Data registers carry no reset, so they map onto slice operand registers.
    always_ff @(posedge clk) begin
      re_q[g+1]  <= re_q[g];
      im_q[g+1]  <= im_q[g];
      cos_q[g+1] <= cos_q[g];
      sin_q[g+1] <= sin_q[g];
    end
  end

  assign q_re  = re_q[STAGES];
  assign q_im  = im_q[STAGES];
  assign q_cos = cos_q[STAGES];
  assign q_sin = sin_q[STAGES];

endmodule

// File: rtl/mixer_mult.sv
module mixer_mult #(
  parameter int DW  = 18,
  parameter int PW  = 16,
  localparam int PRW = mixer_pkg::mix_prod_w(DW, PW)
) (
  input  logic                  clk,
  input  logic signed [DW-1:0]  a,
  input  logic signed [DW-1:0]  b,
  input  logic signed [PW-1:0]  c,
  input  logic signed [PW-1:0]  s,
  output logic signed [PRW-1:0] p_ac,
  output logic signed [PRW-1:0] p_bs,
  output logic signed [PRW-1:0] p_as,
  output logic signed [PRW-1:0] p_bc
);

  // The result is as wide as both operands together, so it holds every bit.
  function automatic logic signed [PRW-1:0] mul_full(
    input logic signed [DW-1:0] x,
    input logic signed [PW-1:0] y
  );
    logic signed [PRW-1:0] xe;
    logic signed [PRW-1:0] ye;
    xe = PRW'(x);
    ye = PRW'(y);
    return xe * ye;
  endfunction

  always_ff @(posedge clk) begin
    p_ac <= mul_full(a, c);
    p_bs <= mul_full(b, s);
    p_as <= mul_full(a, s);
    p_bc <= mul_full(b, c);
  end

endmodule

// File: rtl/mixer_sum.sv
module mixer_sum #(
  parameter int PRW = 34,
  localparam int SW = PRW + 1
) (
  input  logic                  clk,
  input  logic signed [PRW-1:0] p_ac,
  input  logic signed [PRW-1:0] p_bs,
  input  logic signed [PRW-1:0] p_as,
  input  logic signed [PRW-1:0] p_bc,
  output logic signed [SW-1:0]  y_re,
  output logic signed [SW-1:0]  y_im
);

  function automatic logic signed [SW-1:0] widen(input logic signed [PRW-1:0] v);
    return {v[PRW-1], v};
  endfunction

  always_ff @(posedge clk) begin
    y_re <= widen(p_ac) - widen(p_bs);
    y_im <= widen(p_as) + widen(p_bc);
  end

endmodule

// File: rtl/mixer_vld.sv
module mixer_vld #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_in,
  output logic [DEPTH-1:0] v_pipe
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_pipe <= '0;
    else        v_pipe <= {v_pipe[DEPTH-2:0], v_in};
  end

endmodule

// File: rtl/cplx_mixer.sv
module cplx_mixer #(
  parameter int DATA_W  = mixer_pkg::MIX_DATA_W_DEF,
  parameter int PHASE_W = mixer_pkg::MIX_PHASE_W_DEF,
  localparam int PROD_W = mixer_pkg::mix_prod_w(DATA_W, PHASE_W),
  localparam int SUM_W  = mixer_pkg::mix_sum_w(DATA_W, PHASE_W),
  localparam int LAT    = mixer_pkg::MIX_LATENCY
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic signed [DATA_W-1:0]  in_re,
  input  logic signed [DATA_W-1:0]  in_im,
  input  logic signed [PHASE_W-1:0] lo_cos,
  input  logic signed [PHASE_W-1:0] lo_sin,
  output logic                      out_valid,
  output logic signed [SUM_W-1:0]   out_re,
  output logic signed [SUM_W-1:0]   out_im
);

  logic signed [DATA_W-1:0]  op_a, op_b;
  logic signed [PHASE_W-1:0] op_c, op_s;
  logic signed [PROD_W-1:0]  pr_ac, pr_bs, pr_as, pr_bc;
  logic [LAT-1:0]            vld_pipe;
  logic                      prod_vld;

  mixer_in_pipe #(.DW(DATA_W), .PW(PHASE_W), .STAGES(mixer_pkg::MIX_IN_STAGES)) u_in (
    .clk(clk), .d_re(in_re), .d_im(in_im), .p_cos(lo_cos), .p_sin(lo_sin),
    .q_re(op_a), .q_im(op_b), .q_cos(op_c), .q_sin(op_s)
  );

  mixer_mult #(.DW(DATA_W), .PW(PHASE_W)) u_mult (
    .clk(clk), .a(op_a), .b(op_b), .c(op_c), .s(op_s),
    .p_ac(pr_ac), .p_bs(pr_bs), .p_as(pr_as), .p_bc(pr_bc)
  );

  mixer_sum #(.PRW(PROD_W)) u_sum (
    .clk(clk), .p_ac(pr_ac), .p_bs(pr_bs), .p_as(pr_as), .p_bc(pr_bc),
    .y_re(out_re), .y_im(out_im)
  );

  mixer_vld #(.DEPTH(LAT)) u_vld (
    .clk(clk), .rst_n(rst_n), .v_in(in_valid), .v_pipe(vld_pipe)
  );

  // Named tap: the valid flag of the sample that sits in the product registers.
  assign prod_vld  = vld_pipe[LAT-2];
  assign out_valid = vld_pipe[LAT-1];

endmodule

// File: rtl/mixer_chk.sv
module mixer_chk #(
  parameter int DATA_W  = 18,
  parameter int PHASE_W = 16,
  parameter int SUM_W   = 35
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic signed [DATA_W-1:0]  in_re,
  input logic signed [DATA_W-1:0]  in_im,
  input logic signed [PHASE_W-1:0] lo_cos,
  input logic signed [PHASE_W-1:0] lo_sin,
  input logic                      prod_vld,
  input logic                      out_valid,
  input logic signed [SUM_W-1:0]   out_re,
  input logic signed [SUM_W-1:0]   out_im
);

  logic [2:0] since_rst;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 7) since_rst <= since_rst + 3'd1;
  end
  assign warm = (since_rst >= 3'd4);

  function automatic longint ref_re(input longint a, b, c, s);
    return a * c - b * s;
  endfunction
  function automatic longint ref_im(input longint a, b, c, s);
    return a * s + b * c;
  endfunction

  assert_valid_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 4)));

  assert_stage_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(prod_vld)));

  assert_real_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid) |-> (longint'(out_re) == ref_re(longint'($past(in_re, 4)),
      longint'($past(in_im, 4)), longint'($past(lo_cos, 4)), longint'($past(lo_sin, 4)))));

  assert_imag_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid) |-> (longint'(out_im) == ref_im(longint'($past(in_re, 4)),
      longint'($past(in_im, 4)), longint'($past(lo_cos, 4)), longint'($past(lo_sin, 4)))));

endmodule

bind cplx_mixer mixer_chk #(.DATA_W(DATA_W), .PHASE_W(PHASE_W), .SUM_W(SUM_W)) u_mixer_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
  .lo_cos(lo_cos), .lo_sin(lo_sin), .prod_vld(prod_vld), .out_valid(out_valid),
  .out_re(out_re), .out_im(out_im)
);

// File: tb/tb_cplx_mixer.sv
module tb_cplx_mixer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [17:0] in_re = '0, in_im = '0;
  logic signed [15:0] lo_cos = '0, lo_sin = '0;
  logic out_valid;
  logic signed [34:0] out_re, out_im;

  always #4 clk = ~clk;

  cplx_mixer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .lo_cos(lo_cos), .lo_sin(lo_sin), .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // History of driven samples: slot k was driven k+1 negedges ago.
  bit     h_v [4];
  longint h_a [4], h_b [4], h_c [4], h_s [4];
  string  h_tag [4];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint want_re(input longint a, b, c, s);
    return (a * c) - (s * b);
  endfunction
  function automatic longint want_im(input longint a, b, c, s);
    return (c * b) + (s * a);
  endfunction

  task automatic step(input bit v, input longint a, b, c, s, input string tag);
    @(negedge clk);
    if (rst_n) begin
      check(out_valid == h_v[3], "R4 valid delay", longint'(out_valid), longint'(h_v[3]));
      if (h_v[3]) begin
        check(longint'(out_re) == want_re(h_a[3], h_b[3], h_c[3], h_s[3]),
              {"R1 R3 real ", h_tag[3]}, longint'(out_re), want_re(h_a[3], h_b[3], h_c[3], h_s[3]));
        check(longint'(out_im) == want_im(h_a[3], h_b[3], h_c[3], h_s[3]),
              {"R2 R3 imag ", h_tag[3]}, longint'(out_im), want_im(h_a[3], h_b[3], h_c[3], h_s[3]));
      end
    end else begin
      check(out_valid == 1'b0, "R5 reset valid", longint'(out_valid), 0);
    end
    for (int k = 3; k > 0; k--) begin
      h_v[k] = h_v[k-1]; h_a[k] = h_a[k-1]; h_b[k] = h_b[k-1];
      h_c[k] = h_c[k-1]; h_s[k] = h_s[k-1]; h_tag[k] = h_tag[k-1];
    end
    h_v[0] = v && rst_n;
    h_a[0] = a; h_b[0] = b; h_c[0] = c; h_s[0] = s; h_tag[0] = tag;
    in_valid = v;
    in_re = 18'(a); in_im = 18'(b); lo_cos = 16'(c); lo_sin = 16'(s);
  endtask

  task automatic rnd_step(input bit v, input string tag);
    longint a, b, c, s;
    a = longint'($signed(18'($urandom)));
    b = longint'($signed(18'($urandom)));
    c = longint'($signed(16'($urandom)));
    s = longint'($signed(16'($urandom)));
    step(v, a, b, c, s, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4; k++) begin h_v[k] = 0; h_a[k] = 0; h_b[k] = 0; h_c[k] = 0; h_s[k] = 0; h_tag[k] = ""; end
    // R5: valid offered during reset must never emerge.
    for (int i = 0; i < 6; i++) rnd_step(1'b1, "R5");
    @(negedge clk); rst_n = 1'b1;
    in_valid = 1'b0;
    for (int i = 0; i < 5; i++) rnd_step(1'b0, "idle");
    // R6: most-negative corners in all sign mixes.
    for (int m = 0; m < 16; m++) begin
      step(1'b1, m[0] ? -131072 : 131071, m[1] ? -131072 : 131071,
           m[2] ? -32768 : 32767, m[3] ? -32768 : 32767, "R6 corner");
    end
    step(1'b1, -131072, -131072, -32768, -32768, "R6 all-min");
    step(1'b1, 0, 0, 0, 0, "zero");
    // R7: long unbroken valid run.
    for (int i = 0; i < 400; i++) rnd_step(1'b1, "R7 burst");
    // Mixed gaps.
    for (int i = 0; i < 1500; i++) rnd_step(($urandom % 3) != 0, "random");
    for (int i = 0; i < 6; i++) rnd_step(1'b0, "drain");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule